// File: doc/BRIEF.md
# Pipelined CORDIC Sine/Cosine Generator

This block turns a stream of phase words into cosine and sine samples. It uses an unrolled chain of shift-and-add micro-rotations. Each stage is wired for one iteration index, so its shift amount and its arctangent constant are fixed. No barrel shifter and no angle table are needed. The phase is a 32-bit binary angle, where 2^32 counts equal one full turn. A quadrant fold in front of the chain first brings the angle into the range -90 to +90 degrees. It also records whether the final result must be negated, and that flag travels with the sample down the pipe.

Pipeline registers are placed at the input of every GROUP-th stage, and one more register sits at the output. GROUP = 1 registers every stage. A larger GROUP gives fewer cycles of latency but a longer adder path per cycle. GROUP = 0 leaves the whole chain combinational between the input and the single output register. Samples move on valid/ready handshakes. The whole pipe advances as one unit whenever the output register is empty or is being read. `in_ready` reports that same condition. A source must hold `in_valid` and `in_phase` until `in_ready` is seen, and the output holds its sample until `out_ready` is seen.

Outputs are signed fixed point with DW-2 fraction bits, so 1.0 is 2^(DW-2). The x register starts at the reciprocal of the CORDIC gain, which means no output scaling is required.

Top module: `cordic_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R2: For any phase p, `out_cos` and `out_sin` are each within 8 LSB of round(cos(2πp/2^32)·2^(DW-2)) and round(sin(2πp/2^32)·2^(DW-2)).
- R3: The two top phase bits select the quadrant. 0x00000000 gives (+1, 0), 0x40000000 gives (0, +1), 0x80000000 gives (-1, 0), and 0xC0000000 gives (0, -1). Angles one count either side of a quadrant edge give the same results as the edge, within the R2 tolerance.
- R4: When `out_ready` stays high, a phase accepted at clock edge n appears on the outputs, with `out_valid` high, after edge n+L-1, where L = ceil(STAGES/GROUP)+1 (and L = 1 for GROUP = 0).
- R5: With `out_ready` high, one phase is accepted on every clock. N back-to-back phases therefore leave in N consecutive cycles, the last one L+N-1 cycles after the first was accepted.
- R6: Cycles with `in_valid` low produce no output, whatever `in_phase` holds. Results leave in the order their phases were accepted.
- R7: While `out_valid` is high and `out_ready` is low, the outputs and `out_valid` hold still, `in_ready` is 0, and no sample is lost or repeated. At all times `in_ready` equals (not `out_valid`) or `out_ready`.
- R8: When valid, the magnitude of each output never exceeds 2^(DW-2)+4.
- R9: The residual angle left after the last stage never exceeds twice the final stage's arctangent constant plus 64 counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Phase word offered |
| in_ready | output | 1 | Phase word taken at this edge if offered |
| in_phase | input | 32 | Binary angle, 2^32 counts per turn |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink takes the result at this edge |
| out_cos | output | DW | Cosine, signed, DW-2 fraction bits |
| out_sin | output | DW | Sine, signed, DW-2 fraction bits |

## Verification
The assertions check on every cycle that stalled outputs are held, that output magnitudes stay in range, that the residual angle has converged, and that the number of samples in flight never exceeds the number of pipeline slots and is non-zero whenever an output is shown. Numeric accuracy against a real-valued reference can only be shown by the bench scenarios, and so can the quadrant edges, the exact latency, full-rate streaming, valid gaps and ordering under random back-pressure.

// File: rtl/cordic_gen_pkg.sv
`timescale 1ns/1ps
package cordic_gen_pkg;

  // Largest stage count covered by the angle constants below.
  localparam int MAX_STAGES = 31;

  // Reciprocal of the CORDIC gain for a long chain.
  localparam real GAIN_INV = 0.6072529350088813;

  // arctan(2^-idx) as a 32-bit binary angle (2^32 per turn), rounded.
  function automatic logic [31:0] atan_step(input int idx);
    case (idx)
      0:  return 32'h2000_0000;
      1:  return 32'h12E4_051E;
      2:  return 32'h09FB_385B;
      3:  return 32'h0511_11D4;
      4:  return 32'h028B_0D43;
      5:  return 32'h0145_D7E1;
      6:  return 32'h00A2_F61E;
      7:  return 32'h0051_7C55;
      8:  return 32'h0028_BE53;
      9:  return 32'h0014_5F2F;
      10: return 32'h000A_2F98;
      11: return 32'h0005_17CC;
      12: return 32'h0002_8BE6;
      13: return 32'h0001_45F3;
      14: return 32'h0000_A2FA;
      15: return 32'h0000_517D;
      16: return 32'h0000_28BE;
      17: return 32'h0000_145F;
      18: return 32'h0000_0A30;
      19: return 32'h0000_0518;
      20: return 32'h0000_028C;
      21: return 32'h0000_0146;
      22: return 32'h0000_00A3;
      23: return 32'h0000_0051;
      24: return 32'h0000_0029;
      25: return 32'h0000_0014;
      26: return 32'h0000_000A;
      27: return 32'h0000_0005;
      28: return 32'h0000_0003;
      29: return 32'h0000_0001;
      30: return 32'h0000_0001;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/cordic_gen_fold.sv
`timescale 1ns/1ps
// Quadrant fold: brings the angle into [-90, +90) degrees and reports
// whether the final vector has to be negated.
module cordic_gen_fold #(
  parameter int IW = 20,
  parameter int FI = 18
) (
  input  logic [31:0]          phase,
  output logic                 neg,
  output logic signed [IW-1:0] x0,
  output logic signed [IW-1:0] y0,
  output logic [31:0]          z0
);
  import cordic_gen_pkg::*;

  localparam int X0I = $rtoi(GAIN_INV * real'(64'd1 << FI) + 0.5);

  always_comb begin
    // Quadrants 1 and 2 lie outside +-90 degrees: rotate by 180.
    neg = phase[31] ^ phase[30];
    z0  = neg ? (phase ^ 32'h8000_0000) : phase;
    x0  = IW'(X0I);
    y0  = '0;
  end
endmodule

// File: rtl/cordic_gen_stage.sv
`timescale 1ns/1ps
// One micro-rotation with a fixed shift and a fixed angle constant.
module cordic_gen_stage #(
  parameter int IW  = 20,
  parameter int IDX = 0
) (
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic [31:0]          z_i,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic [31:0]          z_o
);
  import cordic_gen_pkg::*;

  localparam logic [31:0] STEP = atan_step(IDX);

  logic                 down;
  logic signed [IW-1:0] xs, ys;

  always_comb begin
    down = z_i[31];
    xs   = x_i >>> IDX;
    ys   = y_i >>> IDX;
    if (down) begin
      x_o = x_i + ys;
      y_o = y_i - xs;
      z_o = z_i + STEP;
    end else begin
      x_o = x_i - ys;
      y_o = y_i + xs;
      z_o = z_i - STEP;
    end
  end
endmodule

// File: rtl/cordic_gen_reg.sv
`timescale 1ns/1ps
// Pipeline slot register with a shared advance enable.
module cordic_gen_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/cordic_gen.sv
`timescale 1ns/1ps
module cordic_gen #(
  parameter int DW     = 16,
  parameter int STAGES = 16,
  parameter int GROUP  = 4,
  parameter int GUARD  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_phase,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_cos,
  output logic [DW-1:0] out_sin
);
  import cordic_gen_pkg::*;

  localparam int IW      = DW + GUARD;
  localparam int FI      = DW - 2 + GUARD;
  localparam int NREG    = (GROUP == 0) ? 0 : (STAGES + GROUP - 1) / GROUP;
  localparam int LATENCY = NREG + 1;
  localparam int ONE     = 1 << (DW - 2);
  localparam int OCW     = $clog2(LATENCY + 2) + 1;
  localparam logic signed [IW:0] HALF = (IW+1)'(1 << (GUARD - 1));
  localparam int RES_MAX = 2 * int'(atan_step(STAGES - 1)) + 64;

  typedef struct packed {
    logic                 vld;
    logic                 neg;
    logic signed [IW-1:0] x;
    logic signed [IW-1:0] y;
    logic [31:0]          z;
  } slot_t;

  localparam int SW = $bits(slot_t);

  slot_t d [STAGES+1];
  slot_t q [STAGES];
  logic  adv;

  // The whole pipe moves when the output slot is empty or being drained.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  logic                 f_neg;
  logic signed [IW-1:0] f_x, f_y;
  logic [31:0]          f_z;

  cordic_gen_fold #(.IW(IW), .FI(FI)) u_fold (
    .phase(in_phase), .neg(f_neg), .x0(f_x), .y0(f_y), .z0(f_z)
  );

  assign d[0] = '{vld: in_valid, neg: f_neg, x: f_x, y: f_y, z: f_z};

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (GROUP > 0 && (i % GROUP) == 0) begin : g_reg
      cordic_gen_reg #(.W(SW)) u_reg (
        .clk(clk), .rst(rst), .en(adv), .d(d[i]), .q(q[i])
      );
    end else begin : g_wire
      assign q[i] = d[i];
    end

    logic signed [IW-1:0] xn, yn;
    logic [31:0]          zn;

    cordic_gen_stage #(.IW(IW), .IDX(i)) u_rot (
      .x_i(q[i].x), .y_i(q[i].y), .z_i(q[i].z),
      .x_o(xn), .y_o(yn), .z_o(zn)
    );

    assign d[i+1] = '{vld: q[i].vld, neg: q[i].neg, x: xn, y: yn, z: zn};
  end

  // Output: undo the quadrant fold, round away the guard bits.
  logic signed [IW:0]   xr, yr;
  logic signed [DW-1:0] cos_n, sin_n;

  always_comb begin
    xr = {d[STAGES].x[IW-1], d[STAGES].x};
    yr = {d[STAGES].y[IW-1], d[STAGES].y};
    if (d[STAGES].neg) begin
      xr = -xr;
      yr = -yr;
    end
    cos_n = DW'((xr + HALF) >>> GUARD);
    sin_n = DW'((yr + HALF) >>> GUARD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_cos   <= '0;
      out_sin   <= '0;
    end else if (adv) begin
      out_valid <= d[STAGES].vld;
      out_cos   <= cos_n;
      out_sin   <= sin_n;
    end
  end

  // Samples in flight, kept only for the checks below.
  logic [OCW-1:0] occ;
  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ + OCW'(in_valid && in_ready) - OCW'(out_valid && out_ready);
  end

  logic [31:0] res_mag;
  assign res_mag = d[STAGES].z[31] ? (~d[STAGES].z + 32'd1) : d[STAGES].z;

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_cos) && $stable(out_sin));

  // R8
  out_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'($signed(out_cos)) <= ONE + 4) && (int'($signed(out_cos)) >= -(ONE + 4))
               && (int'($signed(out_sin)) <= ONE + 4) && (int'($signed(out_sin)) >= -(ONE + 4)));

  // R6
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= LATENCY);

  // R6
  out_source_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> occ != '0);

  // R9
  residual_chk: assert property (@(posedge clk) disable iff (rst)
    d[STAGES].vld |-> res_mag <= 32'(RES_MAX));

endmodule

// File: tb/cordic_gen_test.sv
`timescale 1ns/1ps
module cordic_gen_test;
  localparam int DW     = 16;
  localparam int STAGES = 16;
  localparam int GROUP  = 4;
  localparam int LAT    = (GROUP == 0) ? 1 : (STAGES + GROUP - 1) / GROUP + 1;
  localparam real ONE   = real'(1 << (DW - 2));
  localparam real TOL   = 8.0;
  localparam real TWO_PI = 6.283185307179586;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   in_phase = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_cos, out_sin;

  always #2 clk = ~clk;

  cordic_gen #(.DW(DW), .STAGES(STAGES), .GROUP(GROUP)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase(in_phase), .out_valid(out_valid), .out_ready(out_ready),
    .out_cos(out_cos), .out_sin(out_sin)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int n_out   = 0;
  int last_out_cyc = 0;
  string tag = "R2";
  bit lat_on = 1'b1;
  logic [31:0] exp_q[$];
  int acc_q[$];
  bit prev_hold = 1'b0;
  logic [DW-1:0] prev_c, prev_s;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic chk_val(input logic [31:0] ph, input logic [DW-1:0] c, input logic [DW-1:0] s);
    real ang, ec, es, dc, ds;
    ang = real'(ph) * TWO_PI / 4294967296.0;
    ec = $cos(ang) * ONE;
    es = $sin(ang) * ONE;
    dc = real'(int'($signed(c))) - ec;
    ds = real'(int'($signed(s))) - es;
    n_tests++;
    if (dc > TOL || dc < -TOL || ds > TOL || ds < -TOL) begin
      n_fail++;
      $display("FAIL %s phase %h: actual (%0d,%0d) expected (%0.1f,%0.1f)",
               tag, ph, $signed(c), $signed(s), ec, es);
    end
  endtask

  // Monitor: sampled at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rst) begin
      prev_hold = 1'b0;
    end else begin
      // R7 handshake rule and hold while stalled
      chk(in_ready == (!out_valid || out_ready), "R7", "in_ready rule", int'(in_ready),
          int'(!out_valid || out_ready));
      if (prev_hold)
        chk(out_valid && out_cos == prev_c && out_sin == prev_s, "R7", "held output changed",
            int'(out_cos), int'(prev_c));
      prev_hold = out_valid && !out_ready;
      prev_c = out_cos;
      prev_s = out_sin;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "output with nothing accepted", 1, 0);
        end else begin
          logic [31:0] ph;
          int ac;
          ph = exp_q.pop_front();
          ac = acc_q.pop_front();
          chk_val(ph, out_cos, out_sin);
          if (lat_on) chk(cyc - ac == LAT, "R4", "latency", cyc - ac, LAT);
        end
        n_out++;
        last_out_cyc = cyc;
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(in_phase);
        acc_q.push_back(cyc);
      end
    end
  end

  task automatic send(input logic [31:0] ph);
    bit took;
    in_valid = 1'b1;
    in_phase = ph;
    do begin
      #0.5;
      took = in_ready;
      @(posedge clk);
      #0.5;
    end while (!took);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      in_phase = 32'h9E37_79B9 * (k + 3);
      @(posedge clk);
      #0.5;
    end
  endtask

  task automatic drain(input string req);
    int k;
    in_valid  = 1'b0;
    out_ready = 1'b1;
    k = 0;
    while (exp_q.size() != 0 && k < 200) begin
      @(posedge clk);
      #0.5;
      k++;
    end
    idle(2);
    chk(exp_q.size() == 0, req, "samples left in flight", exp_q.size(), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    in_valid = 1'b1;
    in_phase = 32'h1234_5678;
    repeat (4) @(posedge clk);
    #0.5;
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    in_valid = 1'b0;
    rst = 1'b0;
    @(posedge clk);
    #0.5;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_corners();
    tag = "R3";
    lat_on = 1'b1;
    send(32'h0000_0000); send(32'h4000_0000); send(32'h8000_0000); send(32'hC000_0000);
    send(32'h3FFF_FFFF); send(32'h4000_0001); send(32'h7FFF_FFFF); send(32'h8000_0001);
    send(32'hBFFF_FFFF); send(32'hFFFF_FFFF); send(32'h1555_5555);
    drain("R3");
  endtask

  task automatic t_latency();
    int c0;
    tag = "R4";
    lat_on = 1'b1;
    c0 = cyc;
    send(32'h2AAA_AAAB);
    drain("R4");
    chk(last_out_cyc - c0 == LAT, "R4", "single-sample latency", last_out_cyc - c0, LAT);
  endtask

  task automatic t_sweep();
    tag = "R2";
    lat_on = 1'b1;
    for (int k = 0; k < 256; k++) send(32'h0100_0000 * k + 32'h0003_1415 * (k % 7));
    drain("R2");
  endtask

  task automatic t_stream();
    int c0, n0;
    localparam int N = 40;
    tag = "R5";
    lat_on = 1'b1;
    n0 = n_out;
    c0 = cyc;
    for (int k = 0; k < N; k++) send(32'h0700_0000 * k + 32'h0000_1234);
    drain("R5");
    chk(n_out - n0 == N, "R5", "stream count", n_out - n0, N);
    chk(last_out_cyc - c0 == LAT + N - 1, "R5", "stream end cycle", last_out_cyc - c0, LAT + N - 1);
  endtask

  task automatic t_gaps();
    int n0, sent;
    tag = "R6";
    lat_on = 1'b1;
    n0 = n_out;
    sent = 0;
    for (int k = 0; k < 30; k++) begin
      send(32'hC0DE_0000 + 32'h0555_5555 * k);
      sent++;
      if (k % 3 == 0) idle(1 + (k % 4));
      in_valid = 1'b0;
    end
    drain("R6");
    chk(n_out - n0 == sent, "R6", "outputs vs accepted", n_out - n0, sent);
  endtask

  task automatic t_backpressure();
    int n0, sent, k;
    bit took;
    logic [31:0] ph;
    localparam int N = 50;
    tag = "R7";
    lat_on = 1'b0;
    n0 = n_out;
    sent = 0;
    k = 0;
    ph = 32'h0123_4567;
    while (sent < N && k < 2000) begin
      out_ready = ((k % 3) != 1) && ((k % 7) != 0);
      in_valid = 1'b1;
      in_phase = ph;
      #0.5;
      took = in_ready;
      @(posedge clk);
      #0.5;
      if (took) begin
        ph = ph + 32'h0B00_0013;
        sent++;
      end
      k++;
    end
    in_valid = 1'b0;
    for (int j = 0; j < 6; j++) begin
      out_ready = (j % 2) == 1;
      @(posedge clk);
      #0.5;
    end
    drain("R7");
    chk(n_out - n0 == N, "R7", "outputs under back-pressure", n_out - n0, N);
    lat_on = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog: run exceeded %0d cycles, expected it to end", 150000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #0.5;
    t_reset();
    t_corners();
    t_latency();
    t_sweep();
    t_stream();
    t_gaps();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule